// File: doc/BRIEF.md
# Sticky Timer Event Status with Shared Interrupt

This block gathers one-cycle terminal-count pulses from seven timer channels into one byte-wide status register and drives a single shared interrupt request. Each channel owns one sticky status bit. The bit is set by a pulse and stays set until software reads the status register. That read returns the set bits and clears exactly those bits. A pulse that lands in the same cycle as the read is not returned by that read. It stays pending for the next read, so no event is ever dropped.

Software reaches the block through a simple byte-wide I/O port with an address, read and write strobes, and registered read data. The status register sits at address 0xA0. Bit 0 of that address is a write-only master enable for the request. Per-channel interrupt enables live in a write-only control register at 0xA4. The request is a registered level: it is high while the master enable is set and any enabled status bit is pending, and it falls once a read has cleared the pending bits. Several events can therefore merge into one interrupt, and the service routine must handle every bit it sees set. Three further timer channels that feed other peripherals come in on a separate input. They never touch the status register or the request.

Top module: `evt_status_hub`

## Requirements
- R1: After a synchronous reset, the status bits, the per-channel enables and the master enable are all zero. `irq` is 0, and `rd_data` is 0 until a read is issued.
- R2: A high level on `evt_pulse[k-1]` at a rising clock edge sets status bit k (k = 1..7). The bit then stays set across later edges until a status read clears it.
- R3: A read strobe with `addr` = 0xA0 puts {status[7:1], 1'b0} on `rd_data` in the cycle after the strobe edge, with bit k for channel k and bit 0 always 0. In every other cycle, including after a read of 0xA4 or any other address, `rd_data` is 0.
- R4: A status read clears exactly the bits it returns, and leaves no other bit set unless a pulse arrived in that same cycle.
- R5: A pulse that arrives in the same cycle as a status read is absent from that read's data and is set in the status afterwards.
- R6: A write to 0xA0 leaves the status bits unchanged. Its `wr_data[0]` is stored as the master enable, which gates `irq`.
- R7: A write to 0xA4 stores `wr_data[7:1]` as the enables for channels 1..7 (bit k enables channel k). Bit 0 is ignored.
- R8: `irq` is registered. After each edge it equals master_enable AND OR(status AND enable), using the register values held before that edge. It therefore lags a status or enable change by one cycle and falls one cycle after a read clears the pending bits.
- R9: Pulses on `aux_pulse` (channels 8..10) change neither the status nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 7 | Terminal-count pulses, channels 1..7 |
| aux_pulse | input | 3 | Pulses of channels 8..10, not collected |
| addr | input | 8 | I/O address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Shared interrupt request level |

## Verification
The hardest case to reach is a pulse that lands in exactly the cycle in which software reads the status. Correct behaviour here means the pulse is missing from the returned byte and is still pending afterwards. Pending bits that overlap that read also have to be cleared, and `irq` must behave correctly around it. A directed sequence places a pulse on one channel and then issues the read in the same cycle as a pulse on another channel. A long random phase drives dense pulse traffic, with reads on roughly a quarter of the cycles and occasional enable writes, so that these coincidences occur hundreds of times. Every cycle is compared against a bench model of the register behaviour.

// File: rtl/evt_hub_pkg.sv
package evt_hub_pkg;
  parameter int NUM_CH = 7;
  parameter int AUX_CH = 3;
  parameter int ADDR_W = 8;
  parameter int DATA_W = NUM_CH + 1;
  parameter logic [ADDR_W-1:0] ADDR_STAT = 8'hA0;
  parameter logic [ADDR_W-1:0] ADDR_ENAB = 8'hA4;
endpackage

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_o
);
  // One sticky flop per channel; a set in the clear cycle wins.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) st_o[i] <= 1'b0;
      else     st_o[i] <= (st_o[i] & ~clr_i[i]) | set_i[i];
    end
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((st_o & $past(st_o)) == $past(st_o)));
  // R5
  pulse_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((st_o & $past(set_i)) == $past(set_i)));
  // R4
  clear_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((st_o & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/evt_bus_regs.sv
module evt_bus_regs
  import evt_hub_pkg::*;
#(
  parameter int N = NUM_CH,
  parameter int AW = ADDR_W,
  localparam int DW = N + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [N-1:0]  st_i,
  output logic          stat_rd_o,
  output logic [DW-1:0] rd_data,
  output logic [N-1:0]  en_o,
  output logic          mst_o
);
  logic stat_hit, enab_hit;

  assign stat_hit  = (addr == ADDR_STAT);
  assign enab_hit  = (addr == ADDR_ENAB);
  assign stat_rd_o = rd_en & stat_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      en_o    <= '0;
      mst_o   <= 1'b0;
    end else begin
      rd_data <= stat_rd_o ? {st_i, 1'b0} : '0;
      if (wr_en && stat_hit) mst_o <= wr_data[0];
      if (wr_en && enab_hit) en_o  <= wr_data[DW-1:1];
    end
  end

  // R3
  idle_data_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_rd_o |=> (rd_data == '0));
  // R3
  bit0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd_o |=> (rd_data[0] == 1'b0));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] st_i,
  input  logic [N-1:0] en_i,
  input  logic         mst_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= mst_i & (|(st_i & en_i));
  end

  // R8
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mst_i |=> !irq_o);
  // R8
  no_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_i & en_i) == '0) |=> !irq_o);
endmodule

// File: rtl/evt_status_hub.sv
module evt_status_hub
  import evt_hub_pkg::*;
#(
  parameter int N = NUM_CH,
  parameter int NA = AUX_CH,
  parameter int AW = ADDR_W,
  localparam int DW = N + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt_pulse,
  input  logic [NA-1:0] aux_pulse,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [N-1:0] status, enables, clr_vec;
  logic         master, stat_rd;

  // Clear exactly the bits captured into the read data this cycle.
  assign clr_vec = status & {N{stat_rd}};

  evt_bus_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .st_i(status), .stat_rd_o(stat_rd), .rd_data(rd_data),
    .en_o(enables), .mst_o(master)
  );

  evt_sticky_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst), .set_i(evt_pulse), .clr_i(clr_vec), .st_o(status)
  );

  evt_irq_gen #(.N(N)) u_irq (
    .clk(clk), .rst(rst), .st_i(status), .en_i(enables), .mst_i(master),
    .irq_o(irq)
  );

  // R9
  aux_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (aux_pulse != '0 && evt_pulse == '0 && status == '0) |=> (status == '0));
  // R6
  write_no_status_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !stat_rd && evt_pulse == '0) |=> (status == $past(status)));
endmodule

// File: tb/tb_evt_status_hub.sv
`timescale 1ns/1ps
module tb_evt_status_hub;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] evt_pulse;
  logic [2:0] aux_pulse;
  logic [7:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model state
  logic [6:0] m_st = '0;
  logic [6:0] m_en = '0;
  logic       m_mst = 1'b0;

  always #10 clk = ~clk;

  evt_status_hub dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .aux_pulse(aux_pulse),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic r, input logic [7:0] a,
                                        input logic [6:0] st);
    return (r && a == 8'hA0) ? {st, 1'b0} : 8'h00;
  endfunction

  function automatic logic exp_irq(input logic mst, input logic [6:0] st,
                                   input logic [6:0] en);
    return mst & (|(st & en));
  endfunction

  // One clock cycle: drive at the falling edge, check after the rising edge.
  task automatic cyc(input logic [6:0] p, input logic [2:0] ax, input logic r,
                     input logic w, input logic [7:0] a, input logic [7:0] d,
                     input string tag);
    logic [7:0] e_rd;
    logic       e_irq;
    @(negedge clk);
    evt_pulse = p; aux_pulse = ax; rd_en = r; wr_en = w; addr = a; wr_data = d;
    e_rd  = exp_rd(r, a, m_st);
    e_irq = exp_irq(m_mst, m_st, m_en);
    @(posedge clk);
    if (r && a == 8'hA0) m_st = p;
    else                 m_st = m_st | p;
    if (w && a == 8'hA0) m_mst = d[0];
    if (w && a == 8'hA4) m_en  = d[7:1];
    #2;
    chk(rd_data == e_rd, {tag, " rd_data R3 R4"}, rd_data, e_rd);
    chk(irq == e_irq, {tag, " irq R8"}, {7'd0, irq}, {7'd0, e_irq});
  endtask

  task automatic idle(input string tag);
    cyc('0, '0, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic rd_stat(input logic [6:0] p, input string tag);
    cyc(p, '0, 1'b1, 1'b0, 8'hA0, 8'h00, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; evt_pulse = '0; aux_pulse = '0; addr = '0;
    wr_en = 0; wr_data = '0; rd_en = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
    chk(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    rd_stat('0, "R1 status zero");

    // R2: sticky bits; R3 read data positions
    cyc(7'b0000100, '0, 0, 0, 8'h00, 8'h00, "R2 set ch3");
    idle("R2 hold");
    idle("R2 hold");
    rd_stat('0, "R3 read ch3");
    chk(rd_data == 8'h08, "R3 ch3 at bit3", rd_data, 8'h08);
    rd_stat('0, "R4 cleared");
    chk(rd_data == 8'h00, "R4 empty after read", rd_data, 8'h00);

    // R5: coincident pulse survives
    cyc(7'b0000010, '0, 0, 0, 8'h00, 8'h00, "R5 set ch2");
    rd_stat(7'b0010000, "R5 read with ch5 pulse");
    chk(rd_data == 8'h04, "R5 read has ch2 only", rd_data, 8'h04);
    rd_stat('0, "R5 second read");
    chk(rd_data == 8'h20, "R5 ch5 kept", rd_data, 8'h20);

    // R3: read of 0xA4 returns zero
    cyc(7'b1000000, '0, 0, 0, 8'h00, 8'h00, "R3 set ch7");
    cyc('0, '0, 1, 0, 8'hA4, 8'h00, "R3 read A4");
    chk(rd_data == 8'h00, "R3 A4 reads zero", rd_data, 8'h00);

    // R6: write to 0xA0 keeps status, stores master enable
    cyc('0, '0, 0, 1, 8'hA0, 8'hFF, "R6 write A0");
    // R7: enable ch7 only
    cyc('0, '0, 0, 1, 8'hA4, 8'h80, "R7 enable ch7");
    idle("R8 irq rises");
    chk(irq == 1'b1, "R8 irq high", {7'd0, irq}, 8'h01);
    rd_stat('0, "R6 status kept");
    chk(rd_data == 8'h80, "R6 status unchanged by write", rd_data, 8'h80);
    idle("R8 irq falls");
    chk(irq == 1'b0, "R8 irq low after clear", {7'd0, irq}, 8'h00);

    // R7: disabled channel raises nothing
    cyc(7'b0000001, '0, 0, 0, 8'h00, 8'h00, "R7 ch1 disabled");
    idle("R7 no irq");
    chk(irq == 1'b0, "R7 ch1 disabled irq", {7'd0, irq}, 8'h00);
    rd_stat('0, "R7 clear ch1");

    // R9: aux pulses ignored
    cyc('0, 3'b111, 0, 1, 8'hA4, 8'hFE, "R9 aux + all enables");
    cyc('0, 3'b101, 0, 0, 8'h00, 8'h00, "R9 aux");
    idle("R9 idle");
    chk(irq == 1'b0, "R9 aux no irq", {7'd0, irq}, 8'h00);
    rd_stat('0, "R9 read");
    chk(rd_data == 8'h00, "R9 aux no status", rd_data, 8'h00);

    // R6: master off blocks irq
    cyc(7'b0001000, '0, 0, 1, 8'hA0, 8'h00, "R6 master off");
    idle("R6 gated");
    idle("R6 gated");
    chk(irq == 1'b0, "R6 master gates irq", {7'd0, irq}, 8'h00);
    rd_stat('0, "R6 clear");

    // Random phase: all requirements against the model
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] p;
      logic [7:0] a, d;
      logic r, w;
      int sel;
      p = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      r = ($urandom % 4 == 0);
      w = ($urandom % 10 == 0);
      sel = $urandom % 8;
      a = (sel < 5) ? 8'hA0 : (sel < 7) ? 8'hA4 : 8'($urandom);
      d = 8'($urandom);
      cyc(p, 3'($urandom), r, w, a, d, "rand R2 R5 R7 R9");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule